// File: doc/BRIEF.md
# Register-Driven Nonvolatile Store Access Controller

This block gives a host a two-register window onto a small nonvolatile byte store. The host loads the auxiliary register and then writes a command word with the start flag (bit 15) set. The block runs one read or one write against the store. While it works it shows two flags in the command register: `busy` and, one cycle longer, `running`. The host polls until both read clear before it issues the next command.

Two access widths are supported, chosen per command by a mode bit. In word mode the word address is in the low byte of the command, and the 16-bit data moves through the auxiliary register. In byte mode the auxiliary register holds the byte address instead, and the byte of data moves through the low byte of the command register. The store here is an internal array. It responds after a fixed number of clock cycles, set by a parameter, which stands in for the serial device's access time.

The sequencer has three states. `SEQ_IDLE` waits for a command. An accepted command takes it to `SEQ_ACCESS` ("launch"). `SEQ_ACCESS` counts down the access delay, and its last cycle performs the store operation ("complete"), moving to `SEQ_SETTLE`. `SEQ_SETTLE` holds `running` for one more cycle and then returns to `SEQ_IDLE` ("release").

Top module: `nvm_ctrl`

## Requirements
- R1: After reset, `busy` and `running` read 0, the auxiliary register reads 0, and the command register reads 0 in every field except bit 10.
- R2: A command register write with bit 15 set, accepted on clock edge E, makes `busy` (bit 15) and `running` (bit 11) read 1 after E. `busy` reads 0 after edge E+ACCESS_CYCLES. `running` reads 0 one edge later.
- R3: While `running` reads 1, writes to either register are ignored. The captured command, the auxiliary register and the store are left unchanged.
- R4: Word write: opcode (bits 14:12) 3'b011 with mode bit 9 = 0, and word address A in the low command bits. The 16-bit auxiliary value is stored with its low byte at byte 2A and its high byte at byte 2A+1.
- R5: Word read: opcode 3'b100 with bit 9 = 0. On completion the auxiliary register holds {byte 2A+1, byte 2A}.
- R6: Byte write: opcode 3'b011 with bit 9 = 1 and bit 10 = 1. The byte address comes from the auxiliary register, and the data byte comes from command bits 7:0.
- R7: Byte read: opcode 3'b100 with bit 9 = 1. The byte at the auxiliary-register address appears in command bits 7:0 on completion.
- R8: Command bit 10 reads the `store_writable` input. While it is 0, write commands run with normal timing but leave the store unchanged.
- R9: An opcode other than 3'b011 or 3'b100 runs with normal timing and changes neither the store nor the auxiliary register.
- R10: A command register write with bit 15 clear starts nothing.
- R11: A byte-mode write command with bit 10 written as 0 is refused, and the store is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 auxiliary (word data or byte address) |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data of the selected register |
| store_writable | input | 1 | Store write permission, reflected in command bit 10 |

## Verification
A table of mixed word and byte accesses is walked in order. Words are read back as bytes and bytes as words, so a byte-lane swap or an address scaled wrongly between the two modes shows up as a wrong value. Words at the top of the address space exercise the highest address bits. Directed cases follow the `busy` and `running` fall edge by edge. They also distinguish a command that is ignored because it arrived mid-operation, one refused for lack of write permission, one refused for a missing bit 10, an unknown opcode and a write without the start flag. In each of these cases the store is read back afterwards, so a write that should not have happened is exposed.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACCESS = 2'd1,
        SEQ_SETTLE = 2'd2
    } seq_state_e;

    localparam logic [2:0] OP_WRITE = 3'b011;
    localparam logic [2:0] OP_READ  = 3'b100;

    localparam int BIT_START = 15;
    localparam int BIT_RUN   = 11;
    localparam int BIT_WEN   = 10;
    localparam int BIT_MODE  = 9;
    localparam int OP_LSB    = 12;

endpackage

// File: rtl/nvm_seq.sv
module nvm_seq
    import nvm_pkg::*;
#(
    parameter int ACCESS_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy_o,
    output logic running_o,
    output logic fire_o
);
    localparam int CNT_W = $clog2(ACCESS_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start) begin
                    state_d = SEQ_ACCESS;
                    cnt_d   = CNT_LOAD;
                end
            end
            SEQ_ACCESS: begin
                if (cnt_q == '0) begin
                    state_d = SEQ_SETTLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            SEQ_SETTLE: state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        busy_o    = (state_q == SEQ_ACCESS);
        running_o = (state_q != SEQ_IDLE);
        fire_o    = (state_q == SEQ_ACCESS) && (cnt_q == '0);
    end

    assert_busy_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> running_o);
    assert_run_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |=> !running_o);
    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !running_o) |=> busy_o);
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LOAD);

endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
    parameter int BYTE_AW = 8
) (
    input  logic               clk,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [BYTE_AW-1:0] addr,
    input  logic [15:0]        wdata,
    output logic [15:0]        rdata
);
    localparam int NBYTES = 1 << BYTE_AW;

    logic [7:0]         mem [NBYTES];
    logic [BYTE_AW-1:0] addr_hi;

    assign addr_hi = addr | BYTE_AW'(1);

    always_ff @(posedge clk) begin
        if (wr_lo) mem[addr]    <= wdata[7:0];
        if (wr_hi) mem[addr_hi] <= wdata[15:8];
    end

    assign rdata = {mem[addr_hi], mem[addr]};

endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int BYTE_AW       = 8,
    parameter int ACCESS_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        store_writable
);
    localparam int WORD_AW = BYTE_AW - 1;

    logic               busy, running, fire;
    logic               cmd_wr, aux_wr, start;
    logic [2:0]         op_q;
    logic               mode_q, wen_q;
    logic [7:0]         low_q;
    logic [15:0]        aux_q;
    logic [BYTE_AW-1:0] st_addr;
    logic [15:0]        st_wdata, st_rdata;
    logic               wr_ok, st_wr_lo, st_wr_hi;

    assign cmd_wr = reg_we && !reg_sel;
    assign aux_wr = reg_we && reg_sel;
    assign start  = cmd_wr && reg_wdata[BIT_START] && !running;

    nvm_seq #(.ACCESS_CYCLES(ACCESS_CYCLES)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy_o    (busy),
        .running_o (running),
        .fire_o    (fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            mode_q <= 1'b0;
            wen_q  <= 1'b0;
            low_q  <= '0;
            aux_q  <= '0;
        end else begin
            if (start) begin
                op_q   <= reg_wdata[OP_LSB+2:OP_LSB];
                mode_q <= reg_wdata[BIT_MODE];
                wen_q  <= reg_wdata[BIT_WEN];
                low_q  <= reg_wdata[7:0];
            end
            if (aux_wr && !running) begin
                aux_q <= reg_wdata;
            end
            if (fire && op_q == OP_READ) begin
                if (mode_q) low_q <= st_rdata[7:0];
                else        aux_q <= st_rdata;
            end
        end
    end

    assign st_addr  = mode_q ? aux_q[BYTE_AW-1:0] : {low_q[WORD_AW-1:0], 1'b0};
    assign st_wdata = mode_q ? {8'h00, low_q} : aux_q;
    assign wr_ok    = fire && (op_q == OP_WRITE) && store_writable && (!mode_q || wen_q);
    assign st_wr_lo = wr_ok;
    assign st_wr_hi = wr_ok && !mode_q;

    nvm_store #(.BYTE_AW(BYTE_AW)) store_i (
        .clk   (clk),
        .wr_lo (st_wr_lo),
        .wr_hi (st_wr_hi),
        .addr  (st_addr),
        .wdata (st_wdata),
        .rdata (st_rdata)
    );

    assign reg_rdata = reg_sel ? aux_q
                               : {busy, op_q, running, store_writable, mode_q, 1'b0, low_q};

    assert_ignore_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && running) |=> ($stable(op_q) && $stable(mode_q)));
    assert_ignore_aux_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_wr && running && !(fire && op_q == OP_READ)) |=> $stable(aux_q));
    assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_lo |-> (store_writable && busy));
    assert_byte_wen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_lo && mode_q) |-> (wen_q && !st_wr_hi));

endmodule

// File: tb/nvm_ctrl_tb.sv
`timescale 1ns/1ps
module nvm_ctrl_tb_top;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        store_writable = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    nvm_ctrl #(.BYTE_AW(8), .ACCESS_CYCLES(D)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_we         (reg_we),
        .reg_sel        (reg_sel),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .store_writable (store_writable)
    );

    // entry: {is_write, byte_mode, addr[7:0], data[15:0], expect[15:0]}
    localparam int NV = 11;
    localparam logic [41:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'd3,   16'h1234, 16'h0000},
        {1'b1, 1'b0, 8'd4,   16'h5566, 16'h0000},
        {1'b0, 1'b1, 8'd6,   16'h0000, 16'h0034},
        {1'b0, 1'b1, 8'd7,   16'h0000, 16'h0012},
        {1'b1, 1'b1, 8'd9,   16'h00AB, 16'h0000},
        {1'b0, 1'b0, 8'd4,   16'h0000, 16'hAB66},
        {1'b1, 1'b0, 8'd127, 16'hBEEF, 16'h0000},
        {1'b0, 1'b1, 8'd255, 16'h0000, 16'h00BE},
        {1'b0, 1'b0, 8'd3,   16'h0000, 16'h1234},
        {1'b1, 1'b1, 8'd0,   16'h005A, 16'h0000},
        {1'b0, 1'b1, 8'd0,   16'h0000, 16'h005A}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] val);
        @(negedge clk);
        reg_sel = sel; reg_wdata = val; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [15:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 100; i++) begin
            rd_reg(1'b0, v);
            if (!v[11]) break;
            @(negedge clk);
        end
    endtask

    task automatic word_write(input logic [7:0] a, input logic [15:0] d);
        wr_reg(1'b1, d);
        wr_reg(1'b0, 16'hB000 | {8'h00, a});
        wait_idle();
    endtask

    task automatic word_read(input logic [7:0] a, output logic [15:0] d);
        wr_reg(1'b0, 16'hC000 | {8'h00, a});
        wait_idle();
        rd_reg(1'b1, d);
    endtask

    task automatic byte_write(input logic [7:0] a, input logic [7:0] d);
        wr_reg(1'b1, {8'h00, a});
        wr_reg(1'b0, 16'hB600 | {8'h00, d});
        wait_idle();
    endtask

    task automatic byte_read(input logic [7:0] a, output logic [15:0] d);
        logic [15:0] v;
        wr_reg(1'b1, {8'h00, a});
        wr_reg(1'b0, 16'hC200);
        wait_idle();
        rd_reg(1'b0, v);
        d = {8'h00, v[7:0]};
    endtask

    initial begin
        #1_600_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(1'b0, v); check("R1 cmd", v, 16'h0400);
        rd_reg(1'b1, v); check("R1 aux", v, 16'h0000);

        // Vector table: R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            logic        is_wr, bm;
            logic [7:0]  a;
            logic [15:0] d, e;
            {is_wr, bm, a, d, e} = VEC[i];
            if (is_wr) begin
                if (bm) byte_write(a, d[7:0]);
                else    word_write(a, d);
            end else begin
                if (bm) begin byte_read(a, v); check("R6/R7 byte read", v, e); end
                else    begin word_read(a, v); check("R4/R5 word read", v, e); end
            end
        end

        // R2 exact flag timing
        wr_reg(1'b0, 16'hC003);
        rd_reg(1'b0, v); check("R2 busy+running set", {14'h0, v[15], v[11]}, 16'h0003);
        repeat (D - 1) @(negedge clk);
        rd_reg(1'b0, v); check("R2 busy held", {14'h0, v[15], v[11]}, 16'h0003);
        @(negedge clk);
        rd_reg(1'b0, v); check("R2 busy dropped", {14'h0, v[15], v[11]}, 16'h0001);
        @(negedge clk);
        rd_reg(1'b0, v); check("R2 running dropped", {14'h0, v[15], v[11]}, 16'h0000);
        rd_reg(1'b1, v); check("R5 timed read", v, 16'h1234);

        // R3 writes during an operation are ignored
        wr_reg(1'b0, 16'hC004);
        wr_reg(1'b1, 16'h7777);
        wr_reg(1'b0, 16'hB003);
        rd_reg(1'b0, v); check("R3 cmd unchanged", {8'h00, v[14:12], 5'h0}, 16'h0080);
        check("R3 cmd low unchanged", {8'h00, v[7:0]}, 16'h0004);
        wait_idle();
        rd_reg(1'b1, v); check("R3 aux holds read", v, 16'hAB66);
        word_read(8'd3, v); check("R3 store untouched", v, 16'h1234);

        // R8 write refused without permission
        store_writable = 1'b0;
        @(negedge clk);
        rd_reg(1'b0, v); check("R8 status bit", {15'h0, v[10]}, 16'h0000);
        word_write(8'd3, 16'hFFFF);
        byte_write(8'd7, 8'hEE);
        store_writable = 1'b1;
        word_read(8'd3, v); check("R8 store unchanged", v, 16'h1234);

        // R11 byte write missing bit 10
        wr_reg(1'b1, 16'h0006);
        wr_reg(1'b0, 16'hB277);
        wait_idle();
        byte_read(8'd6, v); check("R11 byte refused", v, 16'h0034);

        // R9 unknown opcode
        wr_reg(1'b1, 16'h9999);
        wr_reg(1'b0, 16'hA003);
        rd_reg(1'b0, v); check("R9 runs", {15'h0, v[15]}, 16'h0001);
        wait_idle();
        rd_reg(1'b1, v); check("R9 aux unchanged", v, 16'h9999);
        word_read(8'd3, v); check("R9 store unchanged", v, 16'h1234);

        // R10 command without start flag
        rd_reg(1'b0, v);
        wr_reg(1'b0, 16'h3005);
        @(negedge clk);
        begin
            logic [15:0] w;
            rd_reg(1'b0, w);
            check("R10 no run", {15'h0, w[11]}, 16'h0000);
            check("R10 cmd unchanged", w, v);
        end
        word_read(8'd5, v);
        word_read(8'd3, v); check("R10 store unchanged", v, 16'h1234);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule